// File: doc/BRIEF.md
# Exception Return Status Unwinder

This block performs the status-word update that a processor core needs when it leaves an exception or non-maskable interrupt handler. When the return strobe is raised, it takes the current 32-bit condition/status word and moves the saved mode fields back into their active positions. The two top bits stay where they are. The block then applies the pending-return rule. For the NMI return it also forces the M flag.

When the restored word selects user mode, the block swaps stacks. The current stack pointer is kept as the kernel stack pointer, and the user stack pointer becomes the live one. All results are registered. They update on the clock edge where the strobe is sampled high, and they hold their values on every other cycle. The surrounding core supplies the return address and performs the branch.

Flag positions in the status word: C=0, V=1, Z=2, N=3, X=4, I=5, U=6, P=7, R=8, M=9.

Top module: `exret_unwinder`

## Requirements
- R1: While `rst_n` is low, `stat_out`, `sp_out` and `ksp_out` are all zero.
- R2: On a strobe, bits 31:30 of `stat_out` equal bits 31:30 of `stat_in`.
- R3: On a strobe, bits 17:0 of `stat_out` take bits 27:10 of `stat_in`, apart from the flag rules in R4 and R7. Bits 29:18 of `stat_out` are zero.
- R4: On a strobe, P (bit 7) is set when R (bit 8) of `stat_in`, taken before the shift, is clear. Otherwise P keeps the shifted value, which is `stat_in` bit 17.
- R5: On a strobe where the new U flag (bit 6, taken from `stat_in` bit 16) is set, `ksp_out` takes `sp_in` and `sp_out` takes `usp_in`.
- R6: On a strobe where the new U flag is clear, `sp_out` takes `sp_in` and `ksp_out` keeps its value.
- R7: With `ret_kind` = 1 (NMI return), M (bit 9) of `stat_out` is forced to 1. With `ret_kind` = 0 (exception return), M keeps the shifted value, which is `stat_in` bit 19.
- R8: While `ret_req` is low, all outputs hold, whatever the other inputs do.
- R9: Outputs change only at the clock edge that samples the strobe, one cycle of latency. Before that edge they show the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_req | input | 1 | Return strobe, one cycle per return |
| ret_kind | input | 1 | 0 = exception return, 1 = NMI return |
| stat_in | input | 32 | Current status word |
| sp_in | input | 32 | Current stack pointer |
| usp_in | input | 32 | Saved user stack pointer |
| stat_out | output | 32 | Unwound status word |
| sp_out | output | 32 | Stack pointer after the return |
| ksp_out | output | 32 | Saved kernel stack pointer |

## Verification
The stimulus words are chosen so that each one isolates a single behaviour:
- An all-zero word and a word with only R set show whether P depends on the old R flag.
- Words whose shifted bit 8 differs from the old bit 8 show whether R is taken before or after the shift.
- Words with the top bits or bits 29:28 set show that only the top pair survives.
- All-ones words with both return kinds show the full field move and the user-stack swap.
- Holds with a changing input while the strobe is low, and a look just before the capturing edge, confirm the hold behaviour and the one-cycle timing.

// File: rtl/exret_pkg.sv
package exret_pkg;
  localparam int WORD_W    = 32;
  localparam int SHIFT_AMT = 10;
  localparam int KEEP_W    = 2;
  localparam int FIELD_W   = 28;

  localparam int FLAG_U = 6;
  localparam int FLAG_P = 7;
  localparam int FLAG_R = 8;
  localparam int FLAG_M = 9;

  typedef enum logic {
    RET_EXC = 1'b0,
    RET_NMI = 1'b1
  } ret_kind_e;
endpackage

// File: rtl/exret_status_shift.sv
module exret_status_shift
  import exret_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int SH    = SHIFT_AMT,
  parameter int KEEP  = KEEP_W,
  parameter int FIELD = FIELD_W
) (
  input  logic [W-1:0] w_in,
  input  logic         is_nmi,
  output logic [W-1:0] w_out,
  output logic         r_was_set,
  output logic         user_next
);
  localparam int MOVED = FIELD - SH;

  logic [W-1:0] shifted;

  // field move: top pair kept, field slides down, rest cleared
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i >= W - KEEP) begin : g_keep
      assign shifted[i] = w_in[i];
    end else if (i < MOVED) begin : g_move
      assign shifted[i] = w_in[i + SH];
    end else begin : g_zero
      assign shifted[i] = 1'b0;
    end
  end

  wire unused_bits = ^{w_in[W-KEEP-1:FIELD], w_in[SH-1:0]};

  assign r_was_set = w_in[FLAG_R];
  assign user_next = shifted[FLAG_U];

  always_comb begin
    w_out = shifted;
    if (!r_was_set) w_out[FLAG_P] = 1'b1;
    if (is_nmi)     w_out[FLAG_M] = 1'b1;
  end
endmodule

// File: rtl/exret_stack_pick.sv
module exret_stack_pick #(
  parameter int W = 32
) (
  input  logic         to_user,
  input  logic [W-1:0] sp_cur,
  input  logic [W-1:0] usp_cur,
  input  logic [W-1:0] ksp_cur,
  output logic [W-1:0] sp_nxt,
  output logic [W-1:0] ksp_nxt
);
  always_comb begin
    if (to_user) begin
      sp_nxt  = usp_cur;
      ksp_nxt = sp_cur;
    end else begin
      sp_nxt  = sp_cur;
      ksp_nxt = ksp_cur;
    end
  end
endmodule

// File: rtl/exret_unwinder.sv
module exret_unwinder
  import exret_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ret_req,
  input  logic         ret_kind,
  input  logic [W-1:0] stat_in,
  input  logic [W-1:0] sp_in,
  input  logic [W-1:0] usp_in,
  output logic [W-1:0] stat_out,
  output logic [W-1:0] sp_out,
  output logic [W-1:0] ksp_out
);
  logic [W-1:0] stat_nxt, sp_nxt, ksp_nxt;
  logic         r_was_set, user_next, is_nmi;

  assign is_nmi = (ret_kind == RET_NMI);

  exret_status_shift #(.W(W)) u_shift (
    .w_in      (stat_in),
    .is_nmi    (is_nmi),
    .w_out     (stat_nxt),
    .r_was_set (r_was_set),
    .user_next (user_next)
  );

  exret_stack_pick #(.W(W)) u_stack (
    .to_user (user_next),
    .sp_cur  (sp_in),
    .usp_cur (usp_in),
    .ksp_cur (ksp_out),
    .sp_nxt  (sp_nxt),
    .ksp_nxt (ksp_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_out <= '0;
      sp_out   <= '0;
      ksp_out  <= '0;
    end else if (ret_req) begin
      stat_out <= stat_nxt;
      sp_out   <= sp_nxt;
      ksp_out  <= ksp_nxt;
    end
  end

  // R8: idle cycles leave every output alone
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_req |=> ($stable(stat_out) && $stable(sp_out) && $stable(ksp_out)));

  // R2: top pair passes through
  a_r2_top_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ret_req |=> stat_out[W-1:W-2] == $past(stat_in[W-1:W-2]));

  // R4: P follows the pre-shift R flag
  a_r4_p_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !stat_in[FLAG_R]) |=> stat_out[FLAG_P]);

  // R7: NMI return forces M
  a_r7_m_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && ret_kind) |=> stat_out[FLAG_M]);

  // R5: stack swap into user mode
  a_r5_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && user_next) |=> (sp_out == $past(usp_in) && ksp_out == $past(sp_in)));

  // R6: no swap keeps kernel copy
  a_r6_no_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !user_next) |=> ($stable(ksp_out) && sp_out == $past(sp_in)));
endmodule

// File: tb/exret_unwinder_test.sv
module exret_unwinder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ret_req = 1'b0;
  logic        ret_kind = 1'b0;
  logic [31:0] stat_in = '0, sp_in = '0, usp_in = '0;
  logic [31:0] stat_out, sp_out, ksp_out;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  exret_unwinder uut (
    .clk(clk), .rst_n(rst_n), .ret_req(ret_req), .ret_kind(ret_kind),
    .stat_in(stat_in), .sp_in(sp_in), .usp_in(usp_in),
    .stat_out(stat_out), .sp_out(sp_out), .ksp_out(ksp_out)
  );

  // {kind, stat_in, expected stat_out}
  localparam int NV = 11;
  localparam logic [64:0] VEC [0:NV-1] = '{
    {1'b0, 32'h0000_0000, 32'h0000_0080},
    {1'b0, 32'h0000_0100, 32'h0000_0000},
    {1'b1, 32'hC000_0000, 32'hC000_0280},
    {1'b0, 32'h0001_0100, 32'h0000_0040},
    {1'b0, 32'h3FFF_FFFF, 32'h0003_FFFF},
    {1'b1, 32'hFFFF_FFFF, 32'hC003_FFFF},
    {1'b1, 32'h0002_0000, 32'h0000_0280},
    {1'b0, 32'h0004_0100, 32'h0000_0100},
    {1'b0, 32'h0004_0000, 32'h0000_0180},
    {1'b0, 32'h3000_0000, 32'h0000_0080},
    {1'b1, 32'h0800_0100, 32'h0002_0200}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] ksp_exp, hold_s, hold_sp, hold_k;
    ksp_exp = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 stat", stat_out, 32'h0);
    check("R1 sp", sp_out, 32'h0);
    check("R1 ksp", ksp_out, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [31:0] exp_s, exp_sp;
      exp_s = VEC[i][31:0];
      @(negedge clk);
      ret_kind = VEC[i][64];
      stat_in  = VEC[i][63:32];
      sp_in    = 32'h0000_1000 + i;
      usp_in   = 32'h0000_8000 + i;
      ret_req  = 1'b1;
      @(negedge clk);
      ret_req = 1'b0;
      if (exp_s[6]) begin
        exp_sp  = usp_in;
        ksp_exp = sp_in;
      end else begin
        exp_sp = sp_in;
      end
      check("R2/R3/R4/R7 stat", stat_out, exp_s);
      check("R5/R6 sp", sp_out, exp_sp);
      check("R5/R6 ksp", ksp_out, ksp_exp);
    end

    // R8: strobe low, inputs move, outputs hold
    hold_s = stat_out; hold_sp = sp_out; hold_k = ksp_out;
    @(negedge clk);
    stat_in = 32'h0000_0000; sp_in = 32'hDEAD_0000; usp_in = 32'hBEEF_0000; ret_kind = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 stat", stat_out, hold_s);
    check("R8 sp", sp_out, hold_sp);
    check("R8 ksp", ksp_out, hold_k);

    // R9: nothing visible before the capturing edge
    stat_in = 32'h0001_0000; ret_kind = 1'b0; sp_in = 32'h0000_2222; usp_in = 32'h0000_3333;
    ret_req = 1'b1;
    #1;
    check("R9 before edge", stat_out, hold_s);
    @(negedge clk);
    ret_req = 1'b0;
    check("R9 after edge", stat_out, 32'h0000_00C0);
    check("R5 sp", sp_out, 32'h0000_3333);
    check("R5 ksp", ksp_out, 32'h0000_2222);

    // R6: no user mode keeps kernel copy
    @(negedge clk);
    stat_in = 32'h0000_0100; sp_in = 32'h0000_4444; usp_in = 32'h0000_5555; ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    check("R6 sp", sp_out, 32'h0000_4444);
    check("R6 ksp", ksp_out, 32'h0000_2222);

    // R1: reset again clears
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 stat again", stat_out, 32'h0);
    check("R1 ksp again", ksp_out, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule